// File: doc/BRIEF.md
# Instruction Stream Prefetch Buffer

This block sits between a first-level instruction cache and a slow DRAM controller. It holds four 32-bit instructions as two 64-bit lines ("halves"), each with its own pair-address tag and valid bit. When the cache asks for a pair address, both tags are compared at once. On a match the stored line is steered onto the cache data bus in the same cycle, so the cache loses only the one cycle of the request.

On a miss the block stalls the cache at once with a synthetic wait and starts a two-beat burst at the requested pair address. The first half is tagged with the requested address and the second with the next one. The DRAM controller's own wait line is not passed to the cache. Instead the block watches it: once the wait has been seen high, each cycle in which it is low delivers one beat. The first beat fills the first half and the second beat fills the second half. The cache's wait stays high without a break until the cycle after the second beat. The requested line is then served from the buffer.

Top module: `instr_stream_prefetch`

## Requirements
- R1: After synchronous active-low reset, `c_wait` and `m_req` are low and both halves are invalid, so the first request of any address is a miss.
- R2: While no fill is in progress and `c_req` is low, `c_wait` and `m_req` are both low.
- R3: A request whose pair address matches a valid half gets `c_wait` low and that half's 64-bit line on `c_data` in the same cycle, and `m_req` stays low.
- R4: A request that matches no valid half raises `c_wait` in the same cycle. From the next cycle `m_req` and `m_burst` are high with `m_addr` equal to the requested pair address, and `c_wait` stays high without a break until the fill ends.
- R5: During a fill, the first cycle with `m_wait` low writes `m_data` into the half tagged with the requested address A. The second such cycle writes the half tagged A+1. No other cycle writes a half.
- R6: `m_req` falls and `c_wait` drops in the cycle after the second beat. The requested line is then served. With a memory that raises its wait in the cycle it sees the request, `c_wait` first reads low 11 cycles after the request was presented.
- R7: A fill at pair address A tags the halves A and A+1 modulo 2^TAG_W. A request for A+1 is then served without a DRAM access, including the wrap from 0x3FF to 0x000.
- R8: Every miss starts a new burst and replaces both halves. This holds for the cold miss after reset, a jump to an unbuffered address, and a sequential miss after two hits.
- R9: While filling, `m_wait` low before it has first been seen high is not a beat. A memory that delays raising its wait lengthens the stall by exactly that delay and does not corrupt the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| c_req | input | 1 | Cache request, held until `c_wait` is low |
| c_addr | input | TAG_W | Requested instruction-pair address |
| c_wait | output | 1 | Synthetic stall to the cache |
| c_data | output | 2*WORD_W | Selected 64-bit line (two instructions) |
| m_req | output | 1 | Request to the DRAM controller |
| m_addr | output | TAG_W | Pair address of the first burst beat |
| m_burst | output | 1 | Burst (two-beat) read select |
| m_wait | input | 1 | DRAM controller wait; a low cycle after a high one is a beat |
| m_data | input | 2*WORD_W | DRAM read data, valid while `m_wait` is low |

## Verification
The bench builds the block with its default parameters: 10-bit pair tags, 32-bit words and two words per half. At these values every tag boundary can be reached, including the wrap of A+1 past 0x3FF. The bench's memory model raises its wait one configurable number of cycles after it sees a request. It then holds the wait high for eight cycles and delivers two consecutive low beats. With no extra delay this gives the 9-cycle first beat and the 10-cycle burst. A non-zero delay makes low wait levels appear inside a fill before the wait has gone high, and these must not be taken as beats. The scenarios cover a cold miss, hits on both halves, a sequential miss after two hits, a jump with wrap, and a delayed memory, and each one checks the exact cycle in which the stall ends.

// File: rtl/pf_pkg.sv
// Package: shared types for the instruction stream prefetch buffer.
// Assumes: nothing; pure type definitions.
package pf_pkg;

    // Fill sequencer states: serving from the buffer, or waiting on a burst.
    typedef enum logic [0:0] {
        PF_IDLE = 1'b0,
        PF_FILL = 1'b1
    } pf_state_t;

endpackage

// File: rtl/pf_half_store.sv
// Module: pf_half_store
// Holds NHALF lines with a tag and valid bit each. On a fill start, half h
// is tagged base_tag + h and invalidated; a write strobe loads and
// validates one half.
// Assumes: at most one write strobe per cycle, strobes in ascending order.
module pf_half_store #(
    parameter int TAG_W  = 10,
    parameter int LINE_W = 64,
    parameter int NHALF  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_tags,
    input  logic [TAG_W-1:0]              base_tag,
    input  logic [NHALF-1:0]              wr_en,
    input  logic [LINE_W-1:0]             wr_data,
    output logic [NHALF-1:0][TAG_W-1:0]   tags,
    output logic [NHALF-1:0]              valid,
    output logic [NHALF-1:0][LINE_W-1:0]  lines
);

    // Tag and valid update: retag on fill start, validate on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags  <= '0;
            valid <= '0;
        end else begin
            for (int h = 0; h < NHALF; h++) begin
                if (load_tags) begin
                    tags[h]  <= base_tag + TAG_W'(h);
                    valid[h] <= 1'b0;
                end else if (wr_en[h]) begin
                    valid[h] <= 1'b1;
                end
            end
        end
    end

    // Line data capture from the memory bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lines <= '0;
        end else begin
            for (int h = 0; h < NHALF; h++) begin
                if (wr_en[h]) lines[h] <= wr_data;
            end
        end
    end

    // R5: never two halves written in one beat.
    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en));

    // R5: a later half is only written once the earlier half is valid.
    for (genvar h = 1; h < NHALF; h++) begin : g_order_chk
        assert_write_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en[h] |-> valid[h-1]);
        // R7: consecutive halves carry consecutive pair addresses.
        assert_tag_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
            valid[h] |-> (tags[h] == tags[h-1] + TAG_W'(1)));
    end

endmodule

// File: rtl/pf_tag_match.sv
// Module: pf_tag_match
// Compares the lookup address with every valid tag in parallel and steers
// the matching line to the output. Purely combinational.
// Assumes: tags of valid halves are distinct, so at most one half matches.
module pf_tag_match #(
    parameter int TAG_W  = 10,
    parameter int LINE_W = 64,
    parameter int NHALF  = 2
) (
    input  logic [TAG_W-1:0]              lookup,
    input  logic [NHALF-1:0][TAG_W-1:0]   tags,
    input  logic [NHALF-1:0]              valid,
    input  logic [NHALF-1:0][LINE_W-1:0]  lines,
    output logic                          hit,
    output logic [LINE_W-1:0]             line_out
);

    logic [NHALF-1:0] match;

    // One comparator per half.
    for (genvar h = 0; h < NHALF; h++) begin : g_cmp
        assign match[h] = valid[h] && (tags[h] == lookup);
    end

    // OR-reduce matches and select the matching line.
    always_comb begin
        hit      = |match;
        line_out = '0;
        for (int h = 0; h < NHALF; h++) begin
            if (match[h]) line_out = line_out | lines[h];
        end
    end

    // R3: distinct consecutive tags give at most one match.
    always_comb begin
        assert_unique_match_R3: assert ($onehot0(match) || $isunknown(match));
    end

endmodule

// File: rtl/pf_fill_ctrl.sv
// Module: pf_fill_ctrl
// Sequences a burst fill on a buffer miss: holds the synthetic cache wait,
// drives the memory request, arms on the first high memory wait and turns
// each following low wait cycle into a write strobe for the next half.
// Assumes: the cache holds c_req and its address until c_wait is low; the
// memory delivers NHALF beats per burst.
module pf_fill_ctrl #(
    parameter int NHALF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             c_req,
    input  logic             hit,
    input  logic             m_wait,
    output logic             load_tags,
    output logic [NHALF-1:0] wr_en,
    output logic             m_req,
    output logic             m_burst,
    output logic             c_wait
);
    import pf_pkg::*;

    localparam int CNT_W = (NHALF > 1) ? $clog2(NHALF) : 1;

    pf_state_t        state;
    logic             armed;
    logic [CNT_W-1:0] beat;
    logic             start;
    logic             beat_now;
    logic             last_beat;

    // Decode of fill start and beat arrival.
    always_comb begin
        start     = (state == PF_IDLE) && c_req && !hit;
        beat_now  = (state == PF_FILL) && armed && !m_wait;
        last_beat = beat_now && (beat == CNT_W'(NHALF - 1));
    end

    // Per-half write strobe from the beat counter.
    for (genvar h = 0; h < NHALF; h++) begin : g_wr
        assign wr_en[h] = beat_now && (beat == CNT_W'(h));
    end

    // Outputs toward cache and memory.
    assign load_tags = start;
    assign m_req     = (state == PF_FILL);
    assign m_burst   = (state == PF_FILL);
    assign c_wait    = (state == PF_FILL) || start;

    // State, arming flag and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PF_IDLE;
            armed <= 1'b0;
            beat  <= '0;
        end else begin
            case (state)
                PF_IDLE: begin
                    armed <= 1'b0;
                    beat  <= '0;
                    if (start) state <= PF_FILL;
                end
                PF_FILL: begin
                    if (m_wait) armed <= 1'b1;
                    if (last_beat) begin
                        state <= PF_IDLE;
                    end else if (beat_now) begin
                        beat <= beat + CNT_W'(1);
                    end
                end
                default: state <= PF_IDLE;
            endcase
        end
    end

    // R2: idle with no request is silent toward both sides.
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_req && !m_req) |-> !c_wait);

    // R3: a hit never launches a memory request.
    assert_hit_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && hit && !m_req) |=> !m_req);

    // R4: a miss requests a burst in the next cycle.
    assert_miss_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !hit && !m_req) |=> (m_req && m_burst));

    // R4: the cache is stalled for as long as memory is busy.
    assert_fill_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> c_wait);

    // R6: the request only ends right after the last beat.
    assert_release_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_req) |-> $past(wr_en[NHALF-1]));

    // R9: no beat is taken before the memory wait has been high.
    assert_no_early_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !armed) |-> (wr_en == '0));

endmodule

// File: rtl/instr_stream_prefetch.sv
// Module: instr_stream_prefetch (top)
// Two-half instruction prefetch buffer between an instruction cache and a
// burst-capable DRAM controller. Hits are served combinationally; misses
// trigger a two-beat burst that refills both halves.
// Assumes: cache holds c_req/c_addr stable until c_wait is low; memory
// data is valid in each cycle m_wait is low after it was seen high.
module instr_stream_prefetch #(
    parameter int TAG_W          = 10,
    parameter int WORD_W         = 32,
    parameter int WORDS_PER_HALF = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               c_req,
    input  logic [TAG_W-1:0]                   c_addr,
    output logic                               c_wait,
    output logic [WORD_W*WORDS_PER_HALF-1:0]   c_data,
    output logic                               m_req,
    output logic [TAG_W-1:0]                   m_addr,
    output logic                               m_burst,
    input  logic                               m_wait,
    input  logic [WORD_W*WORDS_PER_HALF-1:0]   m_data
);

    localparam int LINE_W = WORD_W * WORDS_PER_HALF;
    localparam int NHALF  = 2;

    logic [NHALF-1:0][TAG_W-1:0]  tags;
    logic [NHALF-1:0]             valid;
    logic [NHALF-1:0][LINE_W-1:0] lines;
    logic                         hit;
    logic                         load_tags;
    logic [NHALF-1:0]             wr_en;

    pf_tag_match #(.TAG_W(TAG_W), .LINE_W(LINE_W), .NHALF(NHALF)) u_match (
        .lookup   (c_addr),
        .tags     (tags),
        .valid    (valid),
        .lines    (lines),
        .hit      (hit),
        .line_out (c_data)
    );

    pf_half_store #(.TAG_W(TAG_W), .LINE_W(LINE_W), .NHALF(NHALF)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_tags (load_tags),
        .base_tag  (c_addr),
        .wr_en     (wr_en),
        .wr_data   (m_data),
        .tags      (tags),
        .valid     (valid),
        .lines     (lines)
    );

    pf_fill_ctrl #(.NHALF(NHALF)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .c_req     (c_req),
        .hit       (hit),
        .m_wait    (m_wait),
        .load_tags (load_tags),
        .wr_en     (wr_en),
        .m_req     (m_req),
        .m_burst   (m_burst),
        .c_wait    (c_wait)
    );

    // Burst address is the tag of the first half.
    assign m_addr = tags[0];

    // R4: the burst address is the pair address that missed.
    assert_burst_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !hit && !m_req) |=> (m_addr == $past(c_addr)));

    // R1: nothing is valid in the cycle after reset.
    assert_reset_empty_R1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!hit && !m_req));

endmodule

// File: tb/sim_instr_stream_prefetch.sv
`timescale 1ns/1ps
module sim_instr_stream_prefetch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c_req = 1'b0;
    logic [9:0]  c_addr = '0;
    logic        c_wait;
    logic [63:0] c_data;
    logic        m_req;
    logic [9:0]  m_addr;
    logic        m_burst;
    logic        m_wait = 1'b0;
    logic [63:0] m_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int bursts = 0;
    int raise_delay = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    instr_stream_prefetch u0 (
        .clk(clk), .rst_n(rst_n), .c_req(c_req), .c_addr(c_addr),
        .c_wait(c_wait), .c_data(c_data), .m_req(m_req), .m_addr(m_addr),
        .m_burst(m_burst), .m_wait(m_wait), .m_data(m_data)
    );

    // Memory contents: a line derived from its pair address.
    function automatic logic [63:0] mem_line(logic [9:0] a);
        return {22'h3C0A5, a, 22'h0F1E2, a};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // DRAM model: wait rises raise_delay cycles after the request is seen,
    // stays high 8 cycles, then two consecutive low beats carry A and A+1.
    initial begin
        forever begin
            @(negedge clk);
            if (m_req) begin
                logic [9:0] a;
                a = m_addr;
                bursts++;
                repeat (raise_delay) @(negedge clk);
                m_wait = 1'b1;
                repeat (8) @(negedge clk);
                m_wait = 1'b0;
                m_data = mem_line(a);
                @(negedge clk);
                m_data = mem_line(a + 10'd1);
            end
        end
    end

    // Present a request that must hit (R3).
    task automatic do_hit(logic [9:0] a, string req);
        int b0;
        b0 = bursts;
        @(negedge clk);
        c_req = 1'b1; c_addr = a;
        #1;
        chk(c_wait == 1'b0, {req, " hit wait"}, 64'(c_wait), 64'd0);
        chk(c_data == mem_line(a), {req, " hit data"}, c_data, mem_line(a));
        @(negedge clk);
        c_req = 1'b0;
        #1;
        chk(m_req == 1'b0 && bursts == b0, {req, " R3 no fetch"}, 64'(bursts), 64'(b0));
    endtask

    // Present a request that must miss and fill (R4, R5, R6).
    task automatic do_miss(logic [9:0] a, string req);
        int cyc;
        int b0;
        bit addr_ok;
        bit req_ok;
        b0 = bursts;
        addr_ok = 1; req_ok = 1;
        cyc = 0;
        @(negedge clk);
        c_req = 1'b1; c_addr = a;
        #1;
        chk(c_wait == 1'b1, {req, " R4 miss wait"}, 64'(c_wait), 64'd1);
        while (c_wait && cyc < 100) begin
            @(negedge clk);
            #1;
            cyc++;
            if (c_wait) begin
                if (!(m_req && m_burst)) req_ok = 0;
                if (m_addr != a) addr_ok = 0;
            end
        end
        chk(req_ok, {req, " R4 request held"}, 64'(req_ok), 64'd1);
        chk(addr_ok, {req, " R4 burst address"}, 64'(m_addr), 64'(a));
        chk(cyc == 11 + raise_delay, {req, " R6 release cycle"}, 64'(cyc), 64'(11 + raise_delay));
        chk(m_req == 1'b0, {req, " R6 request dropped"}, 64'(m_req), 64'd0);
        chk(c_data == mem_line(a), {req, " R5 first half data"}, c_data, mem_line(a));
        chk(bursts == b0 + 1, {req, " R8 one burst"}, 64'(bursts), 64'(b0 + 1));
        @(negedge clk);
        c_req = 1'b0;
        #1;
        chk(!c_wait && !m_req, {req, " R2 quiet after"}, {62'd0, c_wait, m_req}, 64'd0);
    endtask

    task automatic t_reset();
        #1;
        chk(!c_wait && !m_req, "R1 reset outputs", {62'd0, c_wait, m_req}, 64'd0);
    endtask

    task automatic t_idle();
        repeat (4) begin
            @(negedge clk);
            #1;
            chk(!c_wait && !m_req, "R2 idle quiet", {62'd0, c_wait, m_req}, 64'd0);
        end
    endtask

    task automatic t_sequential();
        do_miss(10'h010, "R1 R8 cold");
        do_hit(10'h010, "R3 half0");
        do_hit(10'h011, "R7 R5 half1");
        do_miss(10'h012, "R8 after two hits");
        do_hit(10'h013, "R7 next half");
    endtask

    task automatic t_jump_wrap();
        do_miss(10'h3FF, "R8 jump");
        do_hit(10'h000, "R7 wrap");
        do_miss(10'h012, "R8 replaced");
    endtask

    task automatic t_late_memory();
        raise_delay = 3;
        do_miss(10'h155, "R9 late wait");
        do_hit(10'h156, "R9 second half");
        raise_delay = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_idle();
        t_sequential();
        t_jump_wrap();
        t_late_memory();
        t_idle();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule